// File: doc/BRIEF.md
# Capability List Walker

This block is a small sequencer that parses a chain of capability records held in a word-addressed control memory. Each record is a 32-bit header followed by a body of variable size. A `start` pulse clears all earlier results. The walker then reads the header at byte offset 0x58 and decodes it. It acts on the record's type and steps to the next record. It stops on a terminating record, on a malformed or forbidden record, or when the chain would run past the end of the region.

Two pieces of information are collected on the way: an engine clock frequency in MHz, and the offset and size of a mailbox area. When the walk ends, `done` is raised. If the walk aborted, `error` is also raised and `err_code` gives the reason. The captured values stay on the outputs until the next `start`. Anything that fills the memory or uses these values sits outside the block.

Memory reads use a request stream and a response stream, both valid/ready:
- **Request rule.** Once `req_valid` is high, it stays high with a stable `req_addr` until `req_ready` accepts it. The one exception is a `start` pulse, which may withdraw a request that has not been accepted.
- **One read at a time.** At most one read is outstanding.
- **Response rule.** `rsp_ready` is high for exactly as long as a read is outstanding. The memory may hold a response for any number of cycles.
- **Restart.** A response that belongs to a read issued before a restart is accepted and discarded.

Top module: `cap_list_walker`

## Requirements
- R1: A `start` pulse clears `done`, `error`, `err_code`, the frequency and the mailbox values on the next edge and raises `busy`. The first read then targets byte 0x58, which is word address 0x16.
- R2: If the word at byte 0x58 is all zero, the walk ends with `done`=1, `error`=0, frequency 0, mailbox offset 0x1800 and mailbox size 0x1F8.
- R3: The header fields are decoded as follows:
  - bit 31 is the required flag;
  - bits 30:16 are the type;
  - bits 15:0 are the body size in bytes, not counting the header.
  
  The next header is read at entry + 4 + size.
- R4: A body size that is not a multiple of 4 aborts the walk with `err_code` 1.
- R5: Type 2 ends the walk with `done`=1 and `error`=0, and no further reads are made.
- R6: A header of type 0 aborts the walk with `err_code` 2. The one exception is the all-zero word at the start position (R2).
- R7: Type 1 is skipped whatever its required flag. A type above 4 is skipped when the required flag is 0. When that flag is 1, the walk aborts with `err_code` 3.
- R8: For type 3, the word at entry + 4 is read and shown on `freq_mhz`. A type-3 record whose body size is not 4 aborts the walk with `err_code` 1.
- R9: Type 4 sets `mbox_off` to entry + 4 and `mbox_len` to its body size. `mbox_ok` is 1 exactly when `mbox_len` is at least 0x12.
- R10: The walk aborts with `err_code` 4 in either of two cases:
  - a record ends past `REGION_BYTES`;
  - the next header would not fit inside the region.
  
  No read is ever issued outside the region.
- R11: The read interface follows the stream rules stated above. A response that belongs to a read issued before a restart never affects the results.
- R12: Whenever `error` is 1, `done` is also 1. Once `done` is 1, all results hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins or restarts a walk |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | The walk has ended; held until the next start |
| error | output | 1 | The walk aborted |
| err_code | output | 3 | Abort reason: 0 none, 1 size, 2 forbidden type, 3 required unknown type, 4 overrun |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W (11) | Word address of the read |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Walker accepts read data |
| rsp_data | input | 32 | Read data |
| freq_mhz | output | 32 | Captured clock frequency |
| mbox_off | output | 16 | Mailbox byte offset |
| mbox_len | output | 16 | Mailbox size in bytes |
| mbox_ok | output | 1 | Mailbox is large enough to use |

## Verification
The walker is driven with several kinds of lists, each aimed at a different rule:
- an empty region and a list that ends at once, which separate the all-zero start word from a real terminator;
- a list that mixes padding, frequency and mailbox records, which tests step arithmetic and capture together;
- lists with malformed sizes, forbidden types and required unknown types, which test the order in which the checks apply;
- records that end exactly at the region boundary or 4 bytes short of it, which separate an in-bounds last record from a header that would not fit.

Random stalls on both streams, plus restarts at varied delays, test that a stale response is discarded and that the sequence of request addresses does not depend on timing.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_SIZE     = 3'd1,
    ERR_FORBID   = 3'd2,
    ERR_REQUIRED = 3'd3,
    ERR_OVERRUN  = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    K_FORBID, K_PAD, K_END, K_FREQ, K_MBOX, K_OTHER
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE, S_REQ, S_WAIT, S_DONE
  } state_e;

  typedef struct packed {
    logic        required;
    logic [14:0] rtype;
    logic [15:0] size;
  } hdr_t;

  localparam logic [14:0] TY_FORBID = 15'd0;
  localparam logic [14:0] TY_PAD    = 15'd1;
  localparam logic [14:0] TY_END    = 15'd2;
  localparam logic [14:0] TY_FREQ   = 15'd3;
  localparam logic [14:0] TY_MBOX   = 15'd4;

endpackage

// File: rtl/cap_hdr_decode.sv
module cap_hdr_decode
  import cap_walk_pkg::*;
#(
  parameter int REGION_BYTES = 8192,
  parameter int SUM_W        = 18
) (
  input  logic [31:0]      word,
  input  logic [SUM_W-1:0] entry,
  output hdr_t             hdr,
  output kind_e            kind,
  output logic             size_bad,
  output logic             overrun,
  output logic [SUM_W-1:0] next_entry
);
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(REGION_BYTES);

  always_comb begin
    hdr = hdr_t'(word);
    unique case (hdr.rtype)
      TY_FORBID: kind = K_FORBID;
      TY_PAD:    kind = K_PAD;
      TY_END:    kind = K_END;
      TY_FREQ:   kind = K_FREQ;
      TY_MBOX:   kind = K_MBOX;
      default:   kind = K_OTHER;
    endcase
    size_bad   = (hdr.size[1:0] != 2'b00);
    next_entry = entry + SUM_W'(4) + SUM_W'(hdr.size);
    overrun    = (next_entry > LIMIT);
  end
endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter logic [15:0] MBOX_DEF_OFF = 16'h1800,
  parameter logic [15:0] MBOX_DEF_LEN = 16'h01F8,
  parameter logic [15:0] MBOX_MIN     = 16'h0012
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        set_freq,
  input  logic [31:0] freq_in,
  input  logic        set_mbox,
  input  logic [15:0] mbox_off_in,
  input  logic [15:0] mbox_len_in,
  output logic [31:0] freq_mhz,
  output logic [15:0] mbox_off,
  output logic [15:0] mbox_len,
  output logic        mbox_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_mhz <= '0;
      mbox_off <= MBOX_DEF_OFF;
      mbox_len <= MBOX_DEF_LEN;
    end else if (clear) begin
      freq_mhz <= '0;
      mbox_off <= MBOX_DEF_OFF;
      mbox_len <= MBOX_DEF_LEN;
    end else begin
      if (set_freq) freq_mhz <= freq_in;
      if (set_mbox) begin
        mbox_off <= mbox_off_in;
        mbox_len <= mbox_len_in;
      end
    end
  end

  assign mbox_ok = (mbox_len >= MBOX_MIN);

  // R8 / R9: a single response updates at most one capture
  a_r8_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_freq && set_mbox));

  // R1: clearing wins and restores defaults
  a_r1_clear_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (freq_mhz == '0) && (mbox_off == MBOX_DEF_OFF) && (mbox_len == MBOX_DEF_LEN));
endmodule

// File: rtl/cap_list_walker.sv
module cap_list_walker
  import cap_walk_pkg::*;
#(
  parameter int          REGION_BYTES = 8192,
  parameter int          ANCHOR       = 'h58,
  parameter logic [15:0] MBOX_DEF_OFF = 16'h1800,
  parameter logic [15:0] MBOX_DEF_LEN = 16'h01F8,
  parameter logic [15:0] MBOX_MIN     = 16'h0012,
  localparam int         ADDR_W       = $clog2(REGION_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [2:0]        err_code,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  output logic [31:0]       freq_mhz,
  output logic [15:0]       mbox_off,
  output logic [15:0]       mbox_len,
  output logic              mbox_ok
);
  localparam int               SUM_W = 18;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(REGION_BYTES);
  localparam logic [SUM_W-1:0] START_PTR = SUM_W'(ANCHOR);

  state_e           st;
  logic [SUM_W-1:0] entry;
  logic             rd_body;
  logic             first;
  logic             inflight;
  logic             stale;

  logic [SUM_W-1:0] rd_byte;
  logic             req_fire, rsp_fire, take;

  hdr_t             hdr;
  kind_e            kind;
  logic             size_bad, overrun;
  logic [SUM_W-1:0] next_entry;

  logic             fin, go_body, adv, set_freq, set_mbox;
  err_e             fin_code;
  logic [SUM_W-1:0] adv_ptr;

  cap_hdr_decode #(.REGION_BYTES(REGION_BYTES), .SUM_W(SUM_W)) i_dec (
    .word(rsp_data), .entry(entry), .hdr(hdr), .kind(kind),
    .size_bad(size_bad), .overrun(overrun), .next_entry(next_entry)
  );

  cap_store #(.MBOX_DEF_OFF(MBOX_DEF_OFF), .MBOX_DEF_LEN(MBOX_DEF_LEN),
              .MBOX_MIN(MBOX_MIN)) i_store (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .set_freq(set_freq), .freq_in(rsp_data),
    .set_mbox(set_mbox), .mbox_off_in(16'(entry + SUM_W'(4))), .mbox_len_in(hdr.size),
    .freq_mhz(freq_mhz), .mbox_off(mbox_off), .mbox_len(mbox_len), .mbox_ok(mbox_ok)
  );

  always_comb begin
    rd_byte   = rd_body ? entry + SUM_W'(4) : entry;
    req_addr  = rd_byte[ADDR_W+1:2];
    req_valid = (st == S_REQ) && !inflight;
    rsp_ready = inflight;
    req_fire  = req_valid && req_ready;
    rsp_fire  = rsp_valid && rsp_ready;
    take      = rsp_fire && !stale && (st == S_WAIT) && !start;
    busy      = (st == S_REQ) || (st == S_WAIT);
  end

  // decision on a fresh response; checks in priority order
  always_comb begin
    fin      = 1'b0;
    fin_code = ERR_NONE;
    go_body  = 1'b0;
    adv      = 1'b0;
    adv_ptr  = next_entry;
    set_freq = 1'b0;
    set_mbox = 1'b0;
    if (take) begin
      if (rd_body) begin
        set_freq = 1'b1;
        adv      = 1'b1;
        adv_ptr  = entry + SUM_W'(8);
      end else if (first && rsp_data == 32'd0) begin
        fin = 1'b1;
      end else if (size_bad) begin
        fin = 1'b1; fin_code = ERR_SIZE;
      end else if (kind == K_FORBID) begin
        fin = 1'b1; fin_code = ERR_FORBID;
      end else if (overrun) begin
        fin = 1'b1; fin_code = ERR_OVERRUN;
      end else begin
        unique case (kind)
          K_END:  fin = 1'b1;
          K_FREQ: begin
            if (hdr.size != 16'd4) begin
              fin = 1'b1; fin_code = ERR_SIZE;
            end else go_body = 1'b1;
          end
          K_MBOX: begin set_mbox = 1'b1; adv = 1'b1; end
          K_PAD:  adv = 1'b1;
          default: begin
            if (hdr.required) begin
              fin = 1'b1; fin_code = ERR_REQUIRED;
            end else adv = 1'b1;
          end
        endcase
      end
    end
    if (adv && (adv_ptr + SUM_W'(4) > LIMIT)) begin
      adv      = 1'b0;
      fin      = 1'b1;
      fin_code = ERR_OVERRUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      entry    <= '0;
      rd_body  <= 1'b0;
      first    <= 1'b0;
      inflight <= 1'b0;
      stale    <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      inflight <= (inflight && !rsp_fire) || req_fire;
      if (start) begin
        st       <= S_REQ;
        entry    <= START_PTR;
        rd_body  <= 1'b0;
        first    <= 1'b1;
        done     <= 1'b0;
        error    <= 1'b0;
        err_code <= ERR_NONE;
        stale    <= (inflight && !rsp_fire) || req_fire;
      end else begin
        if (rsp_fire && stale) stale <= 1'b0;
        unique case (st)
          S_REQ:  if (req_fire) st <= S_WAIT;
          S_WAIT: if (take) begin
            first <= 1'b0;
            if (fin) begin
              st       <= S_DONE;
              done     <= 1'b1;
              error    <= (fin_code != ERR_NONE);
              err_code <= fin_code;
            end else if (go_body) begin
              rd_body <= 1'b1;
              st      <= S_REQ;
            end else begin
              entry   <= adv_ptr;
              rd_body <= 1'b0;
              st      <= S_REQ;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: an unaccepted request holds its address
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !start) |=> (req_valid && $stable(req_addr)));

  // R10: every issued read lies inside the region
  a_r10_read_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (rd_byte + SUM_W'(4) <= LIMIT));

  // R1: start clears results and begins a walk
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && !error && err_code == 3'd0));

  // R12: error comes only with done
  a_r12_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R12: results hold after the walk ends
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(err_code) && $stable(freq_mhz)
                          && $stable(mbox_off) && $stable(mbox_len)));

  // R5: no reads once finished
  a_r5_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
endmodule

// File: tb/test_cap_list_walker.sv
module test_cap_list_walker;
  localparam int PERIOD = 10;
  localparam int REGION = 8192;
  localparam int WORDS  = REGION / 4;
  localparam int ANCH   = 'h58;
  localparam int AW     = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, error;
  logic [2:0] err_code;
  logic req_valid, req_ready, rsp_valid, rsp_ready;
  logic [AW-1:0] req_addr;
  logic [31:0] rsp_data, freq_mhz;
  logic [15:0] mbox_off, mbox_len;
  logic mbox_ok;

  always #(PERIOD/2) clk = ~clk;

  cap_list_walker i_cap_list_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .err_code(err_code), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .freq_mhz(freq_mhz),
    .mbox_off(mbox_off), .mbox_len(mbox_len), .mbox_ok(mbox_ok)
  );

  // memory model with random stalls
  logic [31:0] mem [0:WORDS-1];
  logic        m_ready, pend;
  logic [AW-1:0] paddr;
  int unsigned dly;
  assign req_ready = m_ready;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready <= 1'b0; pend <= 1'b0; rsp_valid <= 1'b0;
      rsp_data <= '0; paddr <= '0; dly <= 0;
    end else begin
      m_ready <= ($urandom % 4) != 0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (pend && !rsp_valid) begin
        if (dly == 0) begin
          rsp_valid <= 1'b1; rsp_data <= mem[paddr]; pend <= 1'b0;
        end else dly <= dly - 1;
      end
      if (req_valid && req_ready) begin
        pend <= 1'b1; paddr <= req_addr; dly <= $urandom % 3;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  int exp_q[$];
  int e_code, e_freq, e_off, e_len;

  function automatic logic [31:0] hdr(bit rq, int ty, int len);
    return {rq, ty[14:0], len[15:0]};
  endfunction

  function automatic void model();
    int p = ANCH;
    bit first = 1;
    bit stop = 0;
    exp_q.delete();
    e_code = 0; e_freq = 0; e_off = 'h1800; e_len = 'h1F8;
    while (!stop) begin
      logic [31:0] w;
      int len, ty;
      bit rq;
      exp_q.push_back(p / 4);
      w = mem[p / 4];
      len = int'(w[15:0]); ty = int'(w[30:16]); rq = w[31];
      if (first && w == 0) begin stop = 1; continue; end
      first = 0;
      if (len % 4 != 0) begin e_code = 1; stop = 1; continue; end
      if (ty == 0) begin e_code = 2; stop = 1; continue; end
      if (p + 4 + len > REGION) begin e_code = 4; stop = 1; continue; end
      if (ty == 2) begin stop = 1; continue; end
      if (ty == 3) begin
        if (len != 4) begin e_code = 1; stop = 1; continue; end
        exp_q.push_back(p / 4 + 1);
        e_freq = int'(mem[p / 4 + 1]);
      end else if (ty == 4) begin
        e_off = p + 4; e_len = len;
      end else if (ty != 1 && rq) begin
        e_code = 3; stop = 1; continue;
      end
      p = p + 4 + len;
      if (p + 4 > REGION) begin e_code = 4; stop = 1; end
    end
  endfunction

  // per-clock comparison, sampled away from the edge
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && !start) begin
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) chk("R3", "unexpected read", longint'(req_addr), -1);
        else chk("R3", "read address", longint'(req_addr), longint'(exp_q.pop_front()));
      end
      if (done) begin
        chk("R12", "error flag", longint'(error), longint'(e_code != 0));
        chk(cur_tag, "err_code", longint'(err_code), longint'(e_code));
        chk(cur_tag, "freq", longint'(freq_mhz), longint'(e_freq));
        chk(cur_tag, "mbox_off", longint'(mbox_off), longint'(e_off));
        chk(cur_tag, "mbox_len", longint'(mbox_len), longint'(e_len));
        chk("R9", "mbox_ok", longint'(mbox_ok), longint'(e_len >= 'h12));
        chk("R5", "busy while done", longint'(busy), 0);
      end
    end
  end

  task automatic clr();
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  endtask

  task automatic put(int byte_addr, logic [31:0] w);
    mem[byte_addr / 4] = w;
  endtask

  task automatic run(string tag);
    bit ok = 0;
    cur_tag = tag;
    @(negedge clk);
    model();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk("R1", "busy after start", longint'(busy), 1);
    for (int i = 0; i < 3000 && !ok; i++) begin
      @(negedge clk);
      if (done) ok = 1;
    end
    if (!ok) chk(tag, "walk finished", 0, 1);
    repeat (3) @(negedge clk);
    chk(tag, "all reads issued", longint'(exp_q.size()), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a;
    clr();
    repeat (3) @(negedge clk);
    // reset state
    chk("R1", "reset busy", longint'(busy), 0);
    chk("R1", "reset done", longint'(done), 0);
    chk("R1", "reset error", longint'(error), 0);
    chk("R2", "reset mbox_off", longint'(mbox_off), 'h1800);
    chk("R2", "reset mbox_len", longint'(mbox_len), 'h1F8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 empty region
    run("R2");
    // R5 terminator at the start
    clr(); put(ANCH, hdr(0, 2, 0)); run("R5");
    // R3 / R8 / R9 mixed list
    clr(); a = ANCH;
    put(a, hdr(1, 1, 8)); a += 12;
    put(a, hdr(0, 3, 4)); put(a + 4, 32'd1200); a += 8;
    put(a, hdr(0, 4, 'h40)); a += 4 + 'h40;
    put(a, hdr(0, 2, 0));
    run("R8");
    // R7 unknown, not required
    clr(); put(ANCH, hdr(0, 9, 12)); put(ANCH + 16, hdr(0, 2, 0)); run("R7");
    // R7 unknown, required
    clr(); put(ANCH, hdr(1, 9, 0)); run("R7");
    // R6 forbidden type after padding
    clr(); put(ANCH, hdr(0, 1, 4)); run("R6");
    // R4 misaligned size
    clr(); put(ANCH, hdr(0, 1, 6)); run("R4");
    // R8 frequency record of wrong size
    clr(); put(ANCH, hdr(0, 3, 8)); run("R8");
    // R9 small and just-large-enough mailboxes
    clr(); put(ANCH, hdr(0, 4, 'h10)); put(ANCH + 20, hdr(0, 2, 0)); run("R9");
    clr(); put(ANCH, hdr(0, 4, 'h14)); put(ANCH + 24, hdr(0, 2, 0)); run("R9");
    // R10 overrun cases and the in-bounds boundary
    clr(); put(ANCH, hdr(0, 1, 'h2000)); run("R10");
    clr(); put(ANCH, hdr(0, 1, REGION - ANCH - 4)); run("R10");
    clr(); put(ANCH, hdr(0, 1, REGION - ANCH - 8)); put(REGION - 4, hdr(0, 2, 0)); run("R10");

    // R11 restarts at varied points, new list loaded with the restart
    for (int k = 1; k <= 6; k++) begin
      clr(); a = ANCH;
      for (int j = 0; j < 6; j++) begin put(a, hdr(0, 1, 4)); a += 8; end
      put(a, hdr(0, 2, 0));
      cur_tag = "R11";
      @(negedge clk); model(); start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (k) @(negedge clk);
      clr(); put(ANCH, hdr(0, 3, 4)); put(ANCH + 4, 32'd100 + k);
      put(ANCH + 8, hdr(0, 2, 0));
      run("R11");
      chk("R11", "freq after restart", longint'(freq_mhz), 100 + k);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule